// File: doc/BRIEF.md
# Performance Monitor Update Controller

This block owns the snapshot step of a bit-error test's performance counters. Two running counters, one for received bits and one for bit errors, advance on single-cycle strobes from the error detection logic. When an update is triggered, both running values are copied into holding registers that software or a neighbouring block can read at leisure. In the same cycle the running counters restart from zero. A done flag reports that the copy has been made.

The trigger comes from one of two request lines. A mode input chooses between them: a request private to this channel, or a request shared by many channels so that they all take their snapshots together. Only the rising edge of the chosen line counts. Holding the request high produces exactly one update. The done flag stays high until the chosen request falls, which is the handshake a requester waits on before lowering its request.

Because the edge is taken on the selected line, flipping the mode input while the other request is already high looks like a fresh rising edge and starts an update. Integrators must either expect this or keep both requests low while changing the mode.

Top module: `pmu_update_ctrl`

## Requirements
- R1: With `mode_glb` = 0, a 0-to-1 change of `req_loc` triggers one update.
- R2: With `mode_glb` = 1, a 0-to-1 change of `req_glb` triggers one update.
- R3: While the selected request stays high, no further update happens; a new update needs the selected request to go to 0 and back to 1.
- R4: An update loads `bit_hold` and `err_hold` with the running bit and error counts accumulated since the previous update (or reset), and restarts both running counters.
- R5: While `mode_glb` = 1, `req_loc` has no effect: no update starts and the running counts keep accumulating.
- R6: A change of `mode_glb` that makes the newly selected request read 1 where the old one read 0 triggers an update.
- R7: `upd_done` rises on the clock edge that loads the holding registers. It stays high while the selected request is 1 and is 0 one cycle after the selected request reads 0.
- R8: A strobe that arrives in the same cycle as an update is not lost: it is counted as the first event of the new interval.
- R9: The running counters saturate at all ones (2^CNT_W − 1) and do not wrap.
- R10: After reset, `bit_hold`, `err_hold` and `upd_done` are 0 and both running counters are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_glb | input | 1 | Trigger source select: 0 = local request, 1 = global request |
| req_loc | input | 1 | Local update request |
| req_glb | input | 1 | Global (shared) update request |
| bit_stb | input | 1 | One-cycle strobe per received bit |
| err_stb | input | 1 | One-cycle strobe per errored bit |
| bit_hold | output | CNT_W | Bit count captured at the last update |
| err_hold | output | CNT_W | Error count captured at the last update |
| upd_done | output | 1 | Update completed; cleared when the selected request falls |

## Verification
The hardest case to reach from the ports is the update that no request edge starts. It happens when the mode input flips while the request that becomes selected is already high. The stimulus parks one request high in the mode where it is ignored, then flips the mode. The scoreboard holds an expected snapshot for that moment, and any other `upd_done` rise counts as a failure. Running counts are never visible directly. The bench therefore shows that increments are kept in the same cycle as a capture, that the counters saturate, and that local requests in global mode are ignored, each through the value of a later snapshot.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  // Index of each running counter inside the counter arrays
  typedef enum logic [0:0] {
    CNT_BIT = 1'b0,
    CNT_ERR = 1'b1
  } pmu_cnt_e;

  localparam int unsigned PMU_NUM_CNT = 2;
  localparam int unsigned PMU_CNT_W_DEF = 16;
endpackage

// File: rtl/pmu_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset.
module pmu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pmu_trig_sel.sv
// Picks the active request line and detects its rising edge.
module pmu_trig_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_glb,
  input  logic req_loc,
  input  logic req_glb,
  output logic sel_req,
  output logic trig
);
  logic sel_q;
  logic sel_d;

  always_comb begin
    sel_req = mode_glb ? req_glb : req_loc;
    sel_d   = sel_req;
    trig    = sel_req & ~sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/pmu_sat_cnt.sv
// Saturating event counter with a synchronous restart that keeps the
// event of the restart cycle.
module pmu_sat_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = {{(CNT_W-1){1'b0}}, inc};
    end else if (inc && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pmu_snap.sv
// Holding registers and the completion flag.
module pmu_snap #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CNT = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        trig,
  input  logic                        sel_req,
  input  logic [N_CNT-1:0][CNT_W-1:0] run,
  output logic [N_CNT-1:0][CNT_W-1:0] hold,
  output logic                        done
);
  logic done_q;
  logic done_d;
  logic done_en;

  always_comb begin
    done_en = trig | done_q;
    done_d  = sel_req & (done_q | trig);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (done_en) begin
      done_q <= done_d;
    end
  end

  for (genvar gi = 0; gi < N_CNT; gi++) begin : g_hold
    logic [CNT_W-1:0] hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= '0;
      end else if (trig) begin
        hold_q <= run[gi];
      end
    end
    assign hold[gi] = hold_q;
  end

  assign done = done_q;
endmodule

// File: rtl/pmu_update_ctrl.sv
module pmu_update_ctrl
  import pmu_pkg::*;
#(
  parameter int unsigned CNT_W = PMU_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_glb,
  input  logic             req_loc,
  input  logic             req_glb,
  input  logic             bit_stb,
  input  logic             err_stb,
  output logic [CNT_W-1:0] bit_hold,
  output logic [CNT_W-1:0] err_hold,
  output logic             upd_done
);
  localparam int unsigned N_CNT = PMU_NUM_CNT;

  logic                        rst_sync_n;
  logic                        sel_req;
  logic                        trig;
  logic [N_CNT-1:0]            stb;
  logic [N_CNT-1:0][CNT_W-1:0] run;
  logic [N_CNT-1:0][CNT_W-1:0] hold;
  logic [CNT_W-1:0]            bit_run;
  logic [CNT_W-1:0]            err_run;

  pmu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pmu_trig_sel u_trig (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .mode_glb (mode_glb),
    .req_loc  (req_loc),
    .req_glb  (req_glb),
    .sel_req  (sel_req),
    .trig     (trig)
  );

  always_comb begin
    stb          = '0;
    stb[CNT_BIT] = bit_stb;
    stb[CNT_ERR] = err_stb;
  end

  for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
    pmu_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (trig),
      .inc   (stb[gi]),
      .cnt   (run[gi])
    );
  end

  pmu_snap #(.CNT_W(CNT_W), .N_CNT(N_CNT)) u_snap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .trig    (trig),
    .sel_req (sel_req),
    .run     (run),
    .hold    (hold),
    .done    (upd_done)
  );

  assign bit_run  = run[CNT_BIT];
  assign err_run  = run[CNT_ERR];
  assign bit_hold = hold[CNT_BIT];
  assign err_hold = hold[CNT_ERR];
endmodule

// File: rtl/pmu_update_ctrl_chk.sv
module pmu_update_ctrl_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_glb,
  input logic             req_loc,
  input logic             req_glb,
  input logic             trig,
  input logic             upd_done,
  input logic [CNT_W-1:0] bit_hold,
  input logic [CNT_W-1:0] err_hold,
  input logic [CNT_W-1:0] bit_run,
  input logic [CNT_W-1:0] err_run
);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

  AST_LOCAL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_done) && !$past(mode_glb) |-> $past(req_loc)); // R1

  AST_GLOBAL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_done) && $past(mode_glb) |-> $past(req_glb)); // R5

  AST_HOLD_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(upd_done) |-> $stable(bit_hold) && $stable(err_hold)); // R3

  AST_SNAPSHOT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> bit_hold == $past(bit_run) && err_hold == $past(err_run)); // R4

  AST_RESTART_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> bit_run <= 1 && err_run <= 1); // R8

  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_glb ? req_glb : req_loc) |=> !upd_done); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !trig && bit_run == ALL1 && err_run == ALL1 |=> bit_run == ALL1 && err_run == ALL1); // R9
endmodule

bind pmu_update_ctrl pmu_update_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .mode_glb (mode_glb),
  .req_loc  (req_loc),
  .req_glb  (req_glb),
  .trig     (trig),
  .upd_done (upd_done),
  .bit_hold (bit_hold),
  .err_hold (err_hold),
  .bit_run  (bit_run),
  .err_run  (err_run)
);

// File: tb/pmu_update_ctrl_tb.sv
module pmu_update_ctrl_tb;
  localparam int unsigned TB_W = 4;
  localparam int MAXV = (1 << TB_W) - 1;

  typedef struct {
    int    b;
    int    e;
    string req;
  } exp_t;

  logic            clk;
  logic            rst_n;
  logic            mode_glb, req_loc, req_glb, bit_stb, err_stb;
  logic [TB_W-1:0] bit_hold, err_hold;
  logic            upd_done;

  int   checks = 0;
  int   errors = 0;
  exp_t sb_q[$];
  int   mb = 0;
  int   me = 0;
  logic sel_prev = 1'b0;
  logic run_on = 1'b0;
  logic done_seen = 1'b0;
  logic finished = 1'b0;

  pmu_update_ctrl #(.CNT_W(TB_W)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_glb (mode_glb),
    .req_loc  (req_loc),
    .req_glb  (req_glb),
    .bit_stb  (bit_stb),
    .err_stb  (err_stb),
    .bit_hold (bit_hold),
    .err_hold (err_hold),
    .upd_done (upd_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int sat(input int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected snapshot
  task automatic drive(input logic m, input logic lq, input logic gq,
                       input logic b, input logic e, input string tag);
    logic sel;
    @(negedge clk);
    mode_glb = m; req_loc = lq; req_glb = gq; bit_stb = b; err_stb = e;
    sel = m ? gq : lq;
    if (sel && !sel_prev) begin
      sb_q.push_back('{b: mb, e: me, req: tag});
      mb = int'(b);
      me = int'(e);
    end else begin
      mb = sat(mb + int'(b));
      me = sat(me + int'(e));
    end
    sel_prev = sel;
  endtask

  // Sample after the edge that follows the last drive
  task automatic probe_done(input string req, input int exp);
    @(posedge clk);
    #1;
    check(req, int'(upd_done), exp);
  endtask

  // Monitor: every rising upd_done must match the oldest expected item
  always @(negedge clk) begin
    if (run_on) begin
      if (upd_done && !done_seen) begin
        checks++;
        if (sb_q.size() == 0) begin
          errors++;
          $display("FAIL R3/R5 unexpected update actual 1 expected 0");
        end else begin
          exp_t x;
          x = sb_q.pop_front();
          if (int'(bit_hold) != x.b || int'(err_hold) != x.e) begin
            errors++;
            $display("FAIL %s snapshot actual %0d/%0d expected %0d/%0d",
                     x.req, bit_hold, err_hold, x.b, x.e);
          end
        end
      end
      done_seen = upd_done;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mode_glb = 1'b0; req_loc = 1'b0; req_glb = 1'b0; bit_stb = 1'b0; err_stb = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 hold", int'(bit_hold) + int'(err_hold), 0);
    check("R10 done", int'(upd_done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_on = 1'b1;

    // R1 local trigger with distinct counts
    repeat (3) drive(0, 0, 0, 1, 0, "");
    repeat (2) drive(0, 0, 0, 1, 1, "");
    drive(0, 1, 0, 0, 0, "R1");
    probe_done("R7 done high", 1);
    // R3 held request: no second update, hold unchanged
    repeat (4) drive(0, 1, 0, 1, 0, "");
    #1;
    check("R3 hold kept", int'(bit_hold), 5);
    drive(0, 0, 0, 0, 0, "");
    probe_done("R7 done cleared", 0);

    // R8 strobe in the capture cycle
    repeat (2) drive(0, 0, 0, 1, 0, "");
    drive(0, 1, 0, 1, 1, "R4");
    drive(0, 0, 0, 0, 0, "");
    drive(0, 1, 0, 0, 0, "R8");
    drive(0, 0, 0, 0, 0, "");

    // R5 local pulses in global mode are ignored, counts accumulate
    drive(1, 0, 0, 0, 0, "");
    drive(1, 1, 0, 1, 0, "");
    drive(1, 0, 0, 0, 1, "");
    drive(1, 1, 0, 1, 1, "");
    drive(1, 0, 0, 0, 0, "");
    probe_done("R5 no update", 0);
    drive(1, 0, 1, 0, 0, "R2 R5");
    drive(1, 0, 0, 0, 0, "");

    // R6 mode flip with the other request already high
    drive(1, 1, 0, 1, 0, "");
    drive(0, 1, 0, 0, 0, "R6 to local");
    probe_done("R6 done", 1);
    drive(0, 1, 1, 1, 1, "");
    drive(1, 1, 1, 0, 0, "");
    probe_done("R6 no edge on flip with both high", 1);
    drive(1, 1, 0, 0, 0, "");
    probe_done("R7 clear after global drop", 0);
    drive(1, 0, 1, 0, 1, "R6 to global");
    drive(0, 0, 1, 0, 0, "");
    probe_done("R7 clear by mode flip", 0);

    // R9 saturation
    repeat (20) drive(0, 0, 0, 1, 1, "");
    drive(0, 1, 0, 0, 0, "R9");
    drive(0, 0, 0, 0, 0, "");
    repeat (4) drive(0, 0, 0, 0, 0, "");

    check("R3 pending updates", sb_q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule